// File: doc/BRIEF.md
# Symbolic Condition and Bounds Checker

This block decides, one instruction at a time, whether an instruction runs or becomes a no-operation. Each instruction carries a 4-bit condition selector. The block evaluates a set of symbolic conditions on the two operands:

- whether each operand's tag marks a bound value;
- whether each operand's address lies below the choice-point boundary, in which case a binding made now must be trailed;
- whether each operand's address falls inside the current environment frame.

The selected condition gates the instruction's execute enable. When that condition is false, the instruction is squashed in place and no branch is needed.

Alongside these tests the block watches two pairs of facing pointers: the upward and downward stack pointers, and the trail pointer with its limit. When the free gap between the two pointers of either pair drops below a programmable guard margin, a sticky near-collision flag is latched. The flag holds until software clears it with a strobe. Software can then test it, either directly or as the sticky condition, at a point of its own choosing, and no check is needed on every call.

Top module: `sym_cond_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sticky_ovf` is 0.
- R2: Selector 0 gives `exec_en` equal to `instr_valid`. Selector 8, and every reserved value from 9 to 15, gives `exec_en` = 0.
- R3: Selectors 1 and 2 enable execution exactly when the tag of operand A (selector 1) or operand B (selector 2) differs from the unbound tag. The unbound tag is tag value 0 by default.
- R4: Selectors 3 and 4 enable execution exactly when the address of operand A (selector 3) or operand B (selector 4) is strictly less than `choice_bound`, compared as unsigned values.
- R5: Selectors 5 and 6 enable execution exactly when `env_base <= addr < env_limit` holds for operand A (selector 5) or operand B (selector 6). If `env_limit <= env_base`, the frame is empty.
- R6: If `stk_down_ptr - stk_up_ptr` is less than `guard_margin` on a clock edge, `sticky_ovf` is 1 after that edge. The difference is taken as a signed value, so crossed pointers count as a collision.
- R7: If `trail_limit - trail_ptr` is less than `guard_margin` on a clock edge, `sticky_ovf` is 1 after that edge. The difference is taken as a signed value.
- R8: Once set, `sticky_ovf` stays 1 until an edge with `sticky_clr` = 1 and neither near condition present. A clear in a cycle where a near condition holds leaves the flag at 1.
- R9: Selector 7 gives `exec_en` = `instr_valid` AND the current `sticky_ovf`.
- R10: With `instr_valid` = 0, `exec_en` is 0 for every selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| cond_sel | input | 4 | Condition selector carried by the instruction |
| op_a_tag | input | TAG_W | Tag of operand A |
| op_a_addr | input | ADDR_W | Address of operand A |
| op_b_tag | input | TAG_W | Tag of operand B |
| op_b_addr | input | ADDR_W | Address of operand B |
| choice_bound | input | ADDR_W | Choice-point boundary for the trail test |
| env_base | input | ADDR_W | Lowest address of the current environment frame |
| env_limit | input | ADDR_W | First address above the current environment frame |
| trail_ptr | input | ADDR_W | Trail top pointer |
| trail_limit | input | ADDR_W | Trail upper limit |
| stk_up_ptr | input | ADDR_W | Pointer of the upward-growing stack |
| stk_down_ptr | input | ADDR_W | Pointer of the downward-growing stack |
| guard_margin | input | ADDR_W | Minimum free gap before a near collision is flagged |
| sticky_clr | input | 1 | Strobe that clears the sticky flag |
| exec_en | output | 1 | Instruction executes (0 means it becomes a no-operation) |
| sticky_ovf | output | 1 | Sticky near-collision flag |

## Verification
A wrong operand evaluation or a wrong selector decode appears at `exec_en` in the same cycle, because that path is combinational. A sweep of all addresses, tags and selectors against computed comparisons therefore catches it immediately. A fault in the sticky register shows on `sticky_ovf` one edge later, and one of three things happens:

- a missed set leaves the flag at 0 after a short gap;
- a lost hold drops the flag when the pointers return to safe values;
- a clear with the wrong priority shows on the edge of the strobe.

A sweep over pointer pairs and margins, with every outcome checked after a return to safe values, exposes all three.

// File: rtl/sym_cond_pkg.sv
package sym_cond_pkg;

    localparam int NUM_OPS = 2;
    localparam int SEL_W   = 4;
    localparam int WIDE_W  = 33;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALWAYS  = 4'd0,
        SEL_BOUND_A = 4'd1,
        SEL_BOUND_B = 4'd2,
        SEL_TRAIL_A = 4'd3,
        SEL_TRAIL_B = 4'd4,
        SEL_ENV_A   = 4'd5,
        SEL_ENV_B   = 4'd6,
        SEL_STICKY  = 4'd7,
        SEL_NEVER   = 4'd8
    } cond_sel_e;

    typedef struct packed {
        logic bound;
        logic trail;
        logic env;
    } op_flags_t;

    // True when (high - low) < margin, taken as a signed difference.
    function automatic logic gap_short(input logic [WIDE_W-1:0] low,
                                       input logic [WIDE_W-1:0] high,
                                       input logic [WIDE_W-1:0] margin);
        return (low + margin) > high;
    endfunction

endpackage

// File: rtl/sym_operand_eval.sv
module sym_operand_eval
    import sym_cond_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter logic [TAG_W-1:0] UNBOUND_TAG = '0
) (
    input  logic [TAG_W-1:0]  tag,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] choice_bound,
    input  logic [ADDR_W-1:0] env_base,
    input  logic [ADDR_W-1:0] env_limit,
    output op_flags_t         flags
);
    always_comb begin
        flags.bound = (tag != UNBOUND_TAG);
        flags.trail = (addr < choice_bound);
        flags.env   = (addr >= env_base) && (addr < env_limit);
    end
endmodule

// File: rtl/sym_guard_pair.sv
module sym_guard_pair
    import sym_cond_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] low_ptr,
    input  logic [ADDR_W-1:0] high_ptr,
    input  logic [ADDR_W-1:0] margin,
    output logic              near
);
    localparam int PAD = WIDE_W - ADDR_W;

    always_comb begin
        near = gap_short({{PAD{1'b0}}, low_ptr},
                         {{PAD{1'b0}}, high_ptr},
                         {{PAD{1'b0}}, margin});
    end
endmodule

// File: rtl/sym_cond_select.sv
module sym_cond_select
    import sym_cond_pkg::*;
(
    input  op_flags_t [NUM_OPS-1:0] flags,
    input  logic                    sticky,
    input  logic [SEL_W-1:0]        sel,
    input  logic                    valid,
    output logic                    exec_en
);
    logic cond_true;

    always_comb begin
        case (cond_sel_e'(sel))
            SEL_ALWAYS:  cond_true = 1'b1;
            SEL_BOUND_A: cond_true = flags[0].bound;
            SEL_BOUND_B: cond_true = flags[1].bound;
            SEL_TRAIL_A: cond_true = flags[0].trail;
            SEL_TRAIL_B: cond_true = flags[1].trail;
            SEL_ENV_A:   cond_true = flags[0].env;
            SEL_ENV_B:   cond_true = flags[1].env;
            SEL_STICKY:  cond_true = sticky;
            default:     cond_true = 1'b0;
        endcase
        exec_en = valid && cond_true;
    end
endmodule

// File: rtl/sym_cond_unit.sv
module sym_cond_unit
    import sym_cond_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter logic [TAG_W-1:0] UNBOUND_TAG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [3:0]        cond_sel,
    input  logic [TAG_W-1:0]  op_a_tag,
    input  logic [ADDR_W-1:0] op_a_addr,
    input  logic [TAG_W-1:0]  op_b_tag,
    input  logic [ADDR_W-1:0] op_b_addr,
    input  logic [ADDR_W-1:0] choice_bound,
    input  logic [ADDR_W-1:0] env_base,
    input  logic [ADDR_W-1:0] env_limit,
    input  logic [ADDR_W-1:0] trail_ptr,
    input  logic [ADDR_W-1:0] trail_limit,
    input  logic [ADDR_W-1:0] stk_up_ptr,
    input  logic [ADDR_W-1:0] stk_down_ptr,
    input  logic [ADDR_W-1:0] guard_margin,
    input  logic              sticky_clr,
    output logic              exec_en,
    output logic              sticky_ovf
);
    localparam int NUM_PAIRS = 2;

    logic [NUM_OPS-1:0][TAG_W-1:0]  op_tags;
    logic [NUM_OPS-1:0][ADDR_W-1:0] op_addrs;
    op_flags_t [NUM_OPS-1:0]        op_flags;

    logic [NUM_PAIRS-1:0][ADDR_W-1:0] pair_low;
    logic [NUM_PAIRS-1:0][ADDR_W-1:0] pair_high;
    logic [NUM_PAIRS-1:0]             pair_near;

    logic sticky_q;
    logic any_near;

    assign op_tags  = {op_b_tag, op_a_tag};
    assign op_addrs = {op_b_addr, op_a_addr};

    // Pair 0: facing stacks. Pair 1: trail against its limit.
    assign pair_low  = {trail_ptr, stk_up_ptr};
    assign pair_high = {trail_limit, stk_down_ptr};

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        sym_operand_eval #(
            .TAG_W      (TAG_W),
            .ADDR_W     (ADDR_W),
            .UNBOUND_TAG(UNBOUND_TAG)
        ) u_eval (
            .tag         (op_tags[i]),
            .addr        (op_addrs[i]),
            .choice_bound(choice_bound),
            .env_base    (env_base),
            .env_limit   (env_limit),
            .flags       (op_flags[i])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        sym_guard_pair #(
            .ADDR_W(ADDR_W)
        ) u_guard (
            .low_ptr (pair_low[p]),
            .high_ptr(pair_high[p]),
            .margin  (guard_margin),
            .near    (pair_near[p])
        );
    end

    assign any_near = |pair_near;

    // A new near condition wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
        end else begin
            sticky_q <= any_near || (sticky_q && !sticky_clr);
        end
    end

    assign sticky_ovf = sticky_q;

    sym_cond_select u_select (
        .flags  (op_flags),
        .sticky (sticky_q),
        .sel    (cond_sel),
        .valid  (instr_valid),
        .exec_en(exec_en)
    );
endmodule

// File: rtl/sym_cond_checks.sv
module sym_cond_checks #(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter logic [TAG_W-1:0] UNBOUND_TAG = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [3:0]        cond_sel,
    input logic [TAG_W-1:0]  op_a_tag,
    input logic [ADDR_W-1:0] op_a_addr,
    input logic [ADDR_W-1:0] choice_bound,
    input logic [ADDR_W-1:0] trail_ptr,
    input logic [ADDR_W-1:0] trail_limit,
    input logic [ADDR_W-1:0] stk_up_ptr,
    input logic [ADDR_W-1:0] stk_down_ptr,
    input logic [ADDR_W-1:0] guard_margin,
    input logic              sticky_clr,
    input logic              exec_en,
    input logic              sticky_ovf
);
    logic stk_close;
    logic trl_close;

    assign stk_close = ({1'b0, stk_up_ptr} + {1'b0, guard_margin}) > {1'b0, stk_down_ptr};
    assign trl_close = ({1'b0, trail_ptr} + {1'b0, guard_margin}) > {1'b0, trail_limit};

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !sticky_ovf);

    p_always_r2: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd0) |-> (exec_en == instr_valid));

    p_never_r2: assert property (@(posedge clk) disable iff (rst)
        (cond_sel >= 4'd8) |-> !exec_en);

    p_bound_a_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cond_sel == 4'd1) |-> (exec_en == (op_a_tag != UNBOUND_TAG)));

    p_trail_a_r4: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && cond_sel == 4'd3) |-> (exec_en == (op_a_addr < choice_bound)));

    p_stack_set_r6: assert property (@(posedge clk) disable iff (rst)
        stk_close |=> sticky_ovf);

    p_trail_set_r7: assert property (@(posedge clk) disable iff (rst)
        trl_close |=> sticky_ovf);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sticky_ovf && !sticky_clr) |=> sticky_ovf);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (sticky_clr && !stk_close && !trl_close) |=> !sticky_ovf);

    p_sticky_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 4'd7) |-> (exec_en == (instr_valid && sticky_ovf)));

    p_invalid_r10: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !exec_en);
endmodule

bind sym_cond_unit sym_cond_checks #(
    .TAG_W      (TAG_W),
    .ADDR_W     (ADDR_W),
    .UNBOUND_TAG(UNBOUND_TAG)
) u_checks (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .cond_sel    (cond_sel),
    .op_a_tag    (op_a_tag),
    .op_a_addr   (op_a_addr),
    .choice_bound(choice_bound),
    .trail_ptr   (trail_ptr),
    .trail_limit (trail_limit),
    .stk_up_ptr  (stk_up_ptr),
    .stk_down_ptr(stk_down_ptr),
    .guard_margin(guard_margin),
    .sticky_clr  (sticky_clr),
    .exec_en     (exec_en),
    .sticky_ovf  (sticky_ovf)
);

// File: tb/sym_cond_unit_test.sv
`timescale 1ns/1ps
module sym_cond_unit_test;
    localparam int TW = 3;
    localparam int AW = 6;
    localparam int AMAX = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic [3:0]    cond_sel = '0;
    logic [TW-1:0] op_a_tag = '0, op_b_tag = '0;
    logic [AW-1:0] op_a_addr = '0, op_b_addr = '0;
    logic [AW-1:0] choice_bound = '0, env_base = '0, env_limit = '0;
    logic [AW-1:0] trail_ptr = '0, trail_limit = AMAX[AW-1:0];
    logic [AW-1:0] stk_up_ptr = '0, stk_down_ptr = AMAX[AW-1:0];
    logic [AW-1:0] guard_margin = '0;
    logic          sticky_clr = 1'b0;
    logic          exec_en, sticky_ovf;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sym_cond_unit #(.TAG_W(TW), .ADDR_W(AW), .UNBOUND_TAG(3'd0)) uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .cond_sel(cond_sel),
        .op_a_tag(op_a_tag), .op_a_addr(op_a_addr),
        .op_b_tag(op_b_tag), .op_b_addr(op_b_addr),
        .choice_bound(choice_bound), .env_base(env_base), .env_limit(env_limit),
        .trail_ptr(trail_ptr), .trail_limit(trail_limit),
        .stk_up_ptr(stk_up_ptr), .stk_down_ptr(stk_down_ptr),
        .guard_margin(guard_margin), .sticky_clr(sticky_clr),
        .exec_en(exec_en), .sticky_ovf(sticky_ovf)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (sel=%0d a=%0d b=%0d)",
                     req, actual, expected, cond_sel, op_a_addr, op_b_addr);
        end
    endtask

    // Advance past a rising edge; inputs change 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic safe_ptrs();
        stk_up_ptr = '0; stk_down_ptr = AMAX[AW-1:0];
        trail_ptr = '0; trail_limit = AMAX[AW-1:0];
        guard_margin = '0;
    endtask

    function automatic int expect_en(input int sel, input int v, input int st);
        int c;
        case (sel)
            0: c = 1;
            1: c = (op_a_tag != 0);
            2: c = (op_b_tag != 0);
            3: c = (op_a_addr < choice_bound);
            4: c = (op_b_addr < choice_bound);
            5: c = (op_a_addr >= env_base) && (op_a_addr < env_limit);
            6: c = (op_b_addr >= env_base) && (op_b_addr < env_limit);
            7: c = st;
            default: c = 0;
        endcase
        return v & c;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lo_set[3];
        int hi_set[3];
        int cb_set[3];
        lo_set = '{10, 30, 0};
        hi_set = '{30, 10, 63};
        cb_set = '{0, 20, 63};

        tick();
        tick();
        check("R1 reset state", int'(sticky_ovf), 0);
        rst = 1'b0;
        tick();
        check("R1 first cycle after reset", int'(sticky_ovf), 0);

        // R2/R9/R10: every selector with valid high and low, sticky clear.
        for (int s = 0; s < 16; s++) begin
            for (int v = 0; v < 2; v++) begin
                cond_sel = s[3:0]; instr_valid = v[0];
                op_a_tag = 3'd5; op_b_tag = 3'd0; op_a_addr = 6'd3; op_b_addr = 6'd40;
                choice_bound = 6'd20; env_base = 6'd0; env_limit = 6'd63;
                #1;
                if (v == 0) check("R10 invalid squashes", int'(exec_en), 0);
                else if (s == 7) check("R9 sticky select", int'(exec_en), 0);
                else check("R2 selector decode", int'(exec_en), expect_en(s, 1, 0));
            end
        end

        // R3: all tags on both operands.
        instr_valid = 1'b1;
        for (int t = 0; t < 8; t++) begin
            op_a_tag = t[TW-1:0]; op_b_tag = 3'(7 - t);
            cond_sel = 4'd1; #1;
            check("R3 bound operand A", int'(exec_en), (t != 0) ? 1 : 0);
            cond_sel = 4'd2; #1;
            check("R3 bound operand B", int'(exec_en), ((7 - t) != 0) ? 1 : 0);
        end

        // R4/R5: every address under several boundary configurations.
        for (int k = 0; k < 3; k++) begin
            choice_bound = cb_set[k][AW-1:0];
            env_base = lo_set[k][AW-1:0];
            env_limit = hi_set[k][AW-1:0];
            for (int a = 0; a <= AMAX; a++) begin
                op_a_addr = a[AW-1:0]; op_b_addr = 6'(AMAX - a);
                cond_sel = 4'd3; #1;
                check("R4 trail operand A", int'(exec_en), (a < cb_set[k]) ? 1 : 0);
                cond_sel = 4'd4; #1;
                check("R4 trail operand B", int'(exec_en), ((AMAX - a) < cb_set[k]) ? 1 : 0);
                cond_sel = 4'd5; #1;
                check("R5 env operand A", int'(exec_en),
                      (a >= lo_set[k] && a < hi_set[k]) ? 1 : 0);
                cond_sel = 4'd6; #1;
                check("R5 env operand B", int'(exec_en),
                      ((AMAX - a) >= lo_set[k] && (AMAX - a) < hi_set[k]) ? 1 : 0);
            end
        end

        // R6/R7/R8/R9: pointer-pair sweep, flag read after returning to safe values.
        for (int pair = 0; pair < 2; pair++) begin
            for (int lo = 0; lo <= AMAX; lo += 3) begin
                for (int hi = 0; hi <= AMAX; hi += 5) begin
                    for (int m = 0; m < 8; m++) begin
                        int exp_near;
                        exp_near = ((hi - lo) < m) ? 1 : 0;
                        safe_ptrs();
                        guard_margin = m[AW-1:0];
                        if (pair == 0) begin
                            stk_up_ptr = lo[AW-1:0]; stk_down_ptr = hi[AW-1:0];
                        end else begin
                            trail_ptr = lo[AW-1:0]; trail_limit = hi[AW-1:0];
                        end
                        tick();
                        safe_ptrs();
                        #1;
                        check(pair == 0 ? "R6 stack gap sets flag" : "R7 trail gap sets flag",
                              int'(sticky_ovf), exp_near);
                        tick();
                        check("R8 flag holds", int'(sticky_ovf), exp_near);
                        cond_sel = 4'd7; #1;
                        check("R9 sticky select", int'(exec_en), exp_near);
                        sticky_clr = 1'b1;
                        tick();
                        sticky_clr = 1'b0;
                        #1;
                        check("R8 clear", int'(sticky_ovf), 0);
                    end
                end
            end
        end

        // R8: clear while a near condition holds keeps the flag.
        safe_ptrs();
        guard_margin = 6'd4; stk_up_ptr = 6'd20; stk_down_ptr = 6'd21;
        tick();
        sticky_clr = 1'b1;
        tick();
        sticky_clr = 1'b0;
        #1;
        check("R8 set beats clear", int'(sticky_ovf), 1);
        safe_ptrs();
        sticky_clr = 1'b1;
        tick();
        sticky_clr = 1'b0;
        #1;
        check("R8 clear after safe", int'(sticky_ovf), 0);

        // R1: reset clears a set flag.
        stk_up_ptr = 6'd50; stk_down_ptr = 6'd10;
        tick();
        safe_ptrs();
        rst = 1'b1;
        tick();
        check("R1 reset clears flag", int'(sticky_ovf), 0);
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule